// File: doc/BRIEF.md
# Sampled Multi-Port Event Counter Bank

This block is a bank of ten programmable event counters that watch the traffic of five monitored bus ports. Each port presents, every clock cycle, a write byte amount, a read byte amount, and four single-bit strobes: write transaction start, read transaction start, write beat and read beat. Each counter has an 8-bit selector. The selector picks one port and one metric, so the ten counters can be spread across the ports in any mix. For example, all ten can sit on one port, or two can sit on each port.

A single programmable down-counter sets the sampling period. Each time it expires, every live counter is copied at once into its own sampled register, and software reads those registers. Optionally, the live counters restart from zero at each expiry, so that each sample holds the traffic of exactly one interval. A free-running global cycle counter gives software a time base. All configuration and readout go through a simple 32-bit register write/read port at fixed offsets.

Top module: `evt_metric_bank`

## Requirements
- R1: Counter i takes its selector from byte (i mod 4) of the register at offset 0x44 + 4*(i div 4). In that byte, bits [4:0] are the metric code and bits [7:5] are the port index. The selector registers read back as written.
- R2: The metric codes are 0 write transaction starts, 1 read transaction starts, 2 write bytes, 3 read bytes, 4 write beats and 5 read beats. A byte metric adds that cycle's byte amount. A strobe metric adds 1 for each cycle in which its strobe is high. For example, a selector byte of 0x62 accumulates write bytes of port 3.
- R3: A metric code above 5, or a port index above 4, makes the counter count nothing.
- R4: Bit 0 of the control register (offset 0x300) enables all live counters. While it is 0, events leave the counters unchanged.
- R5: Writing 1 to bit 1 of the control register clears every live counter and every sampled counter on that clock edge.
- R6: Writing 1 to bit 1 of the interval control register (offset 0x28) loads the interval register (offset 0x24) into the down-counter. Bit 0 enables the down-counter. With an interval of N (N ≥ 1), an expiry occurs every N cycles, and the down-counter reloads itself from the interval register after each expiry.
- R7: On each expiry, every sampled counter takes the value of its live counter. At all other times, the sampled counters hold their value, except under R5. Sampled counter i is read at offset 0x200 + 4*i, zero-extended to 32 bits.
- R8: When bit 8 of the interval control register is 1, each expiry restarts the live counters from that cycle's own increment. In this mode, a strobe held high continuously gives a sample equal to N.
- R9: A live counter saturates at all ones instead of wrapping.
- R10: In the control register, bit 16 enables the global cycle counter, which then adds 1 every cycle, and bit 17 clears it. The global counter is read at offset 0x000.
- R11: After reset, every register and counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | 12 | Register byte offset |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Read data for csr_addr_i (combinational) |
| mon_wr_bytes_i | input | N_PORTS*BYTE_W | Per-port write byte amount this cycle |
| mon_rd_bytes_i | input | N_PORTS*BYTE_W | Per-port read byte amount this cycle |
| mon_wr_start_i | input | N_PORTS | Per-port write transaction start strobe |
| mon_rd_start_i | input | N_PORTS | Per-port read transaction start strobe |
| mon_wr_beat_i | input | N_PORTS | Per-port write beat strobe |
| mon_rd_beat_i | input | N_PORTS | Per-port read beat strobe |

## Verification
A selector that decodes the wrong port or metric shows up as a wrong total in the sampled word of that counter, at the first expiry after the stimulus stops. A down-counter off by one cycle does not change a static total. It does show, one interval later, as a sample of N±1 when a strobe is held high in restart mode. A missed clear, or a live counter that wraps, is visible at the next read of the affected sampled word. The global counter is checked by the exact difference between two reads a fixed number of cycles apart.

// File: rtl/emb_pkg.sv
package emb_pkg;

    localparam int CSR_AW = 12;
    localparam int CSR_DW = 32;
    localparam int MET_W  = 5;
    localparam int PORT_W = 3;

    typedef enum logic [MET_W-1:0] {
        MET_WR_XACT  = 5'd0,
        MET_RD_XACT  = 5'd1,
        MET_WR_BYTES = 5'd2,
        MET_RD_BYTES = 5'd3,
        MET_WR_BEAT  = 5'd4,
        MET_RD_BEAT  = 5'd5
    } metric_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [MET_W-1:0]  metric;
    } sel_t;

    typedef struct packed {
        logic ctr_en;
        logic gcnt_en;
        logic tmr_en;
        logic clr_on_exp;
    } cfg_t;

    typedef struct packed {
        logic clr_all;
        logic gcnt_clr;
        logic tmr_load;
    } pulse_t;

    localparam logic [CSR_AW-1:0] ADR_GCNT  = 12'h000;
    localparam logic [CSR_AW-1:0] ADR_IVAL  = 12'h024;
    localparam logic [CSR_AW-1:0] ADR_ICTL  = 12'h028;
    localparam logic [CSR_AW-1:0] ADR_SEL0  = 12'h044;
    localparam logic [CSR_AW-1:0] ADR_SAMP0 = 12'h200;
    localparam logic [CSR_AW-1:0] ADR_CTRL  = 12'h300;

    function automatic logic [CSR_AW-1:0] word_adr(logic [CSR_AW-1:0] base, int idx);
        return base + CSR_AW'(idx * 4);
    endfunction

endpackage

// File: rtl/emb_csr.sv
module emb_csr import emb_pkg::*; #(
    parameter int N_CNT  = 10,
    parameter int CNT_W  = 32,
    parameter int GCNT_W = 32,
    parameter int TMR_W  = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          wr_i,
    input  logic [CSR_AW-1:0]             addr_i,
    input  logic [CSR_DW-1:0]             wdata_i,
    output logic [CSR_DW-1:0]             rdata_o,
    input  logic [N_CNT-1:0][CNT_W-1:0]   samp_i,
    input  logic [GCNT_W-1:0]             gcnt_i,
    output cfg_t                          cfg_o,
    output pulse_t                        pulse_o,
    output logic [TMR_W-1:0]              interval_o,
    output sel_t [N_CNT-1:0]              sel_o
);
    localparam int N_SELREG = (N_CNT + 3) / 4;

    logic [N_SELREG-1:0][CSR_DW-1:0] selreg;
    logic wr_ctrl, wr_ictl;

    assign wr_ctrl = wr_i && (addr_i == ADR_CTRL);
    assign wr_ictl = wr_i && (addr_i == ADR_ICTL);

    assign pulse_o.clr_all  = wr_ctrl && wdata_i[1];
    assign pulse_o.gcnt_clr = wr_ctrl && wdata_i[17];
    assign pulse_o.tmr_load = wr_ictl && wdata_i[1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_o      <= '0;
            interval_o <= '0;
            selreg     <= '0;
        end else if (wr_i) begin
            if (wr_ctrl) begin
                cfg_o.ctr_en  <= wdata_i[0];
                cfg_o.gcnt_en <= wdata_i[16];
            end
            if (wr_ictl) begin
                cfg_o.tmr_en     <= wdata_i[0];
                cfg_o.clr_on_exp <= wdata_i[8];
            end
            if (addr_i == ADR_IVAL)
                interval_o <= wdata_i[TMR_W-1:0];
            for (int k = 0; k < N_SELREG; k++)
                if (addr_i == word_adr(ADR_SEL0, k))
                    selreg[k] <= wdata_i;
        end
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_sel
        assign sel_o[i] = selreg[i/4][8*(i%4) +: 8];
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADR_GCNT)
            rdata_o = CSR_DW'(gcnt_i);
        if (addr_i == ADR_IVAL)
            rdata_o = CSR_DW'(interval_o);
        if (addr_i == ADR_ICTL)
            rdata_o = {23'd0, cfg_o.clr_on_exp, 7'd0, cfg_o.tmr_en};
        if (addr_i == ADR_CTRL)
            rdata_o = {15'd0, cfg_o.gcnt_en, 15'd0, cfg_o.ctr_en};
        for (int k = 0; k < N_SELREG; k++)
            if (addr_i == word_adr(ADR_SEL0, k))
                rdata_o = selreg[k];
        for (int i = 0; i < N_CNT; i++)
            if (addr_i == word_adr(ADR_SAMP0, i))
                rdata_o = CSR_DW'(samp_i[i]);
    end

endmodule

// File: rtl/emb_interval_timer.sv
module emb_interval_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [TMR_W-1:0] interval_i,
    output logic             tick_o
);
    logic [TMR_W-1:0] remain;
    logic             last;

    assign last   = (remain <= TMR_W'(1));
    assign tick_o = en_i && !load_i && last;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            remain <= '0;
        else if (load_i)
            remain <= interval_i;
        else if (en_i)
            remain <= last ? interval_i : remain - TMR_W'(1);
    end

endmodule

// File: rtl/emb_counter_lane.sv
module emb_counter_lane import emb_pkg::*; #(
    parameter int N_PORTS = 5,
    parameter int CNT_W   = 32,
    parameter int BYTE_W  = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  sel_t                      sel_i,
    input  logic [N_PORTS*BYTE_W-1:0] wr_bytes_i,
    input  logic [N_PORTS*BYTE_W-1:0] rd_bytes_i,
    input  logic [N_PORTS-1:0]        wr_start_i,
    input  logic [N_PORTS-1:0]        rd_start_i,
    input  logic [N_PORTS-1:0]        wr_beat_i,
    input  logic [N_PORTS-1:0]        rd_beat_i,
    input  logic                      ctr_en_i,
    input  logic                      clr_all_i,
    input  logic                      tick_i,
    input  logic                      clr_on_exp_i,
    output logic [CNT_W-1:0]          live_o,
    output logic [CNT_W-1:0]          samp_o
);
    logic [BYTE_W-1:0] p_wb, p_rb, inc;
    logic              p_ws, p_rs, p_wt, p_rt;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  live_sat;

    // port pick: an index with no matching port leaves every event at zero
    always_comb begin
        p_wb = '0; p_rb = '0;
        p_ws = 1'b0; p_rs = 1'b0; p_wt = 1'b0; p_rt = 1'b0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (sel_i.port == PORT_W'(p)) begin
                p_wb = wr_bytes_i[p*BYTE_W +: BYTE_W];
                p_rb = rd_bytes_i[p*BYTE_W +: BYTE_W];
                p_ws = wr_start_i[p];
                p_rs = rd_start_i[p];
                p_wt = wr_beat_i[p];
                p_rt = rd_beat_i[p];
            end
        end
    end

    always_comb begin
        case (sel_i.metric)
            MET_WR_XACT:  inc = BYTE_W'(p_ws);
            MET_RD_XACT:  inc = BYTE_W'(p_rs);
            MET_WR_BYTES: inc = p_wb;
            MET_RD_BYTES: inc = p_rb;
            MET_WR_BEAT:  inc = BYTE_W'(p_wt);
            MET_RD_BEAT:  inc = BYTE_W'(p_rt);
            default:      inc = '0;
        endcase
    end

    assign sum      = {1'b0, live_o} + (CNT_W+1)'(inc);
    assign live_sat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_all_i) begin
            live_o <= '0;
            samp_o <= '0;
        end else begin
            if (tick_i)
                samp_o <= live_o;
            if (tick_i && clr_on_exp_i)
                live_o <= ctr_en_i ? CNT_W'(inc) : '0;
            else if (ctr_en_i)
                live_o <= live_sat;
        end
    end

endmodule

// File: rtl/evt_metric_bank.sv
module evt_metric_bank import emb_pkg::*; #(
    parameter int N_CNT   = 10,
    parameter int N_PORTS = 5,
    parameter int CNT_W   = 32,
    parameter int BYTE_W  = 8,
    parameter int GCNT_W  = 32,
    parameter int TMR_W   = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      csr_wr_i,
    input  logic [11:0]               csr_addr_i,
    input  logic [31:0]               csr_wdata_i,
    output logic [31:0]               csr_rdata_o,
    input  logic [N_PORTS*BYTE_W-1:0] mon_wr_bytes_i,
    input  logic [N_PORTS*BYTE_W-1:0] mon_rd_bytes_i,
    input  logic [N_PORTS-1:0]        mon_wr_start_i,
    input  logic [N_PORTS-1:0]        mon_rd_start_i,
    input  logic [N_PORTS-1:0]        mon_wr_beat_i,
    input  logic [N_PORTS-1:0]        mon_rd_beat_i
);
    cfg_t                        cfg;
    pulse_t                      pulse;
    logic [TMR_W-1:0]            interval;
    sel_t [N_CNT-1:0]            sel;
    logic                        tick;
    logic [N_CNT-1:0][CNT_W-1:0] live_all;
    logic [N_CNT-1:0][CNT_W-1:0] samp_all;
    logic [GCNT_W-1:0]           gcnt;

    emb_csr #(
        .N_CNT(N_CNT), .CNT_W(CNT_W), .GCNT_W(GCNT_W), .TMR_W(TMR_W)
    ) u_csr (
        .clk_i(clk_i), .rst_i(rst_i),
        .wr_i(csr_wr_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i),
        .rdata_o(csr_rdata_o),
        .samp_i(samp_all), .gcnt_i(gcnt),
        .cfg_o(cfg), .pulse_o(pulse), .interval_o(interval), .sel_o(sel)
    );

    emb_interval_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk_i(clk_i), .rst_i(rst_i),
        .en_i(cfg.tmr_en), .load_i(pulse.tmr_load),
        .interval_i(interval), .tick_o(tick)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_lane
        emb_counter_lane #(
            .N_PORTS(N_PORTS), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
        ) u_lane (
            .clk_i(clk_i), .rst_i(rst_i), .sel_i(sel[i]),
            .wr_bytes_i(mon_wr_bytes_i), .rd_bytes_i(mon_rd_bytes_i),
            .wr_start_i(mon_wr_start_i), .rd_start_i(mon_rd_start_i),
            .wr_beat_i(mon_wr_beat_i), .rd_beat_i(mon_rd_beat_i),
            .ctr_en_i(cfg.ctr_en), .clr_all_i(pulse.clr_all),
            .tick_i(tick), .clr_on_exp_i(cfg.clr_on_exp),
            .live_o(live_all[i]), .samp_o(samp_all[i])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || pulse.gcnt_clr)
            gcnt <= '0;
        else if (cfg.gcnt_en)
            gcnt <= gcnt + GCNT_W'(1);
    end

endmodule

// File: rtl/emb_checker.sv
module emb_checker import emb_pkg::*; #(
    parameter int N_CNT  = 10,
    parameter int CNT_W  = 32,
    parameter int GCNT_W = 32
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic                        tick,
    input cfg_t                        cfg,
    input pulse_t                      pulse,
    input logic [N_CNT-1:0][CNT_W-1:0] live_all,
    input logic [N_CNT-1:0][CNT_W-1:0] samp_all,
    input logic [GCNT_W-1:0]           gcnt
);
    assert_sample_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick && !pulse.clr_all) |=> $stable(samp_all));

    assert_sample_copy_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick && !pulse.clr_all) |=> (samp_all == $past(live_all)));

    assert_clear_all_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse.clr_all |=> (samp_all == '0 && live_all == '0));

    assert_tick_needs_en_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        tick |-> cfg.tmr_en);

    assert_gcnt_step_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg.gcnt_en && !pulse.gcnt_clr) |=> (gcnt == $past(gcnt) + GCNT_W'(1)));

    assert_gcnt_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cfg.gcnt_en && !pulse.gcnt_clr) |=> $stable(gcnt));

    for (genvar i = 0; i < N_CNT; i++) begin : g_mono
        assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            (!pulse.clr_all && !(tick && cfg.clr_on_exp)) |=> (live_all[i] >= $past(live_all[i])));
    end

endmodule

bind evt_metric_bank emb_checker #(
    .N_CNT(N_CNT), .CNT_W(CNT_W), .GCNT_W(GCNT_W)
) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick(tick), .cfg(cfg), .pulse(pulse),
    .live_all(live_all), .samp_all(samp_all), .gcnt(gcnt)
);

// File: tb/evt_metric_bank_tb_top.sv
`timescale 1ns/1ps
module evt_metric_bank_tb_top;
    localparam int NP = 5;
    localparam int BW = 8;
    localparam int CW = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csr_wr = 1'b0;
    logic [11:0]       csr_addr = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic [NP*BW-1:0]  wr_bytes = '0, rd_bytes = '0;
    logic [NP-1:0]     wr_start = '0, rd_start = '0, wr_beat = '0, rd_beat = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    evt_metric_bank #(.N_PORTS(NP), .BYTE_W(BW), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .csr_wr_i(csr_wr), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
        .csr_rdata_o(csr_rdata),
        .mon_wr_bytes_i(wr_bytes), .mon_rd_bytes_i(rd_bytes),
        .mon_wr_start_i(wr_start), .mon_rd_start_i(rd_start),
        .mon_wr_beat_i(wr_beat), .mon_rd_beat_i(rd_beat)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // monitor: pops the scoreboard as reads are presented
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_pend) chk(csr_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        csr_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_pend = 1'b1;
        @(negedge clk);
        rd_pend = 1'b0;
    endtask

    task automatic idle_ev();
        wr_bytes = '0; rd_bytes = '0;
        wr_start = '0; rd_start = '0; wr_beat = '0; rd_beat = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] samp_adr(input int i);
        return 12'h200 + 12'(4 * i);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v1, v2;
        logic [31:0] exp_tot[10];
        wait_cyc(3);
        rst = 1'b0;

        // R11 reset state
        expect_rd(12'h300, 32'h0, "R11 ctrl");
        expect_rd(12'h028, 32'h0, "R11 ictl");
        expect_rd(12'h044, 32'h0, "R11 sel");
        expect_rd(12'h200, 32'h0, "R11 samp0");
        expect_rd(12'h000, 32'h0, "R11 gcnt");

        // R1 selectors: c0=0x62 c1=0x01 c2=0x83 c3=0x25 c4=0xA2 c5=0x49 c6=0x60 c7=0x64 c8=0x02 c9=0x43
        wr(12'h044, 32'h25830162);
        wr(12'h048, 32'h6460_49A2);
        wr(12'h04C, 32'h0000_4302);
        expect_rd(12'h044, 32'h25830162, "R1 sel reg0");
        expect_rd(12'h04C, 32'h00004302, "R1 sel reg2");

        wr(12'h300, 32'h1);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            wr_bytes[3*BW +: BW] = BW'(c + 1);
            wr_start[3] = (c % 4 == 0);
            wr_beat[3] = 1'b1;
            rd_start[0] = c[0];
            wr_bytes[0*BW +: BW] = 8'd7;
            rd_bytes[4*BW +: BW] = 8'd3;
            rd_beat[1] = (c < 5);
            rd_bytes[2*BW +: BW] = 8'd2;
            wr_bytes[2*BW +: BW] = 8'd9;
        end
        @(negedge clk);
        idle_ev();

        // R7 nothing sampled while the timer is off
        expect_rd(samp_adr(0), 32'h0, "R7 no expiry yet");

        // R6 load and enable timer, R7 sample copy
        wr(12'h024, 32'd5);
        wr(12'h028, 32'h2);
        wr(12'h028, 32'h1);
        wait_cyc(12);
        exp_tot = '{210, 10, 60, 5, 0, 0, 5, 20, 140, 40};
        for (int i = 0; i < 10; i++) begin
            string t;
            case (i)
                4: t = "R3 bad port";
                5: t = "R3 bad metric";
                0, 2, 8, 9: t = "R2 byte metric";
                default: t = "R2 strobe metric";
            endcase
            expect_rd(samp_adr(i), exp_tot[i], t);
        end

        // R4 disabled counters ignore events
        wr(12'h300, 32'h0);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            wr_bytes[3*BW +: BW] = 8'd1;
            wr_beat[3] = 1'b1;
        end
        @(negedge clk);
        idle_ev();
        wait_cyc(12);
        expect_rd(samp_adr(0), 32'd210, "R4 disabled bytes");
        expect_rd(samp_adr(7), 32'd20, "R4 disabled beats");

        // R5 clear all
        wr(12'h300, 32'h2);
        expect_rd(samp_adr(0), 32'h0, "R5 clear samp0");
        expect_rd(samp_adr(7), 32'h0, "R5 clear samp7");
        wait_cyc(8);
        expect_rd(samp_adr(8), 32'h0, "R5 live cleared");

        // R8 restart on expiry, R6 period
        wr(12'h300, 32'h1);
        wr(12'h028, 32'h101);
        expect_rd(12'h028, 32'h101, "R6 ictl readback");
        @(negedge clk);
        wr_start[3] = 1'b1;
        wait_cyc(15);
        expect_rd(samp_adr(6), 32'd5, "R8 period 5");
        wr(12'h024, 32'd8);
        wr(12'h028, 32'h103);
        wait_cyc(25);
        expect_rd(samp_adr(6), 32'd8, "R6 reload 8");
        wait_cyc(9);
        expect_rd(samp_adr(6), 32'd8, "R8 repeat 8");
        @(negedge clk);
        idle_ev();

        // R9 saturation
        wr(12'h028, 32'h1);
        wr(12'h300, 32'h3);
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            wr_bytes[3*BW +: BW] = 8'd255;
            wr_beat[3] = 1'b1;
        end
        @(negedge clk);
        idle_ev();
        wait_cyc(20);
        expect_rd(samp_adr(0), 32'h0000FFFF, "R9 saturate");
        expect_rd(samp_adr(7), 32'd300, "R2 beats 300");

        // R10 global counter
        wr(12'h300, 32'h20000);
        expect_rd(12'h000, 32'h0, "R10 gclear");
        wr(12'h300, 32'h10000);
        expect_rd(12'h300, 32'h10000, "R10 ctrl readback");
        @(negedge clk);
        csr_addr = 12'h000;
        #1 v1 = csr_rdata;
        wait_cyc(10);
        #1 v2 = csr_rdata;
        chk(v2, v1 + 32'd10, "R10 step");
        wr(12'h300, 32'h0);
        @(negedge clk);
        #1 v1 = csr_rdata;
        wait_cyc(6);
        #1 v2 = csr_rdata;
        chk(v2, v1, "R10 hold");
        wr(12'h300, 32'h20000);
        expect_rd(12'h000, 32'h0, "R10 clear");

        wait_cyc(2);
        finish_run();
    end

endmodule